// File: doc/BRIEF.md
# Charlieplex Frame Transposer

This block turns a window of column bytes into the per-row line-enable masks that a charlieplexed LED scanner drives. With `LINES` signal lines the panel has `LINES` rows but only `LINES-1` usable columns, because a line cannot be both the anode and the cathode of one LED. The block therefore transposes a non-square bit matrix. `LINES-1` column bytes are spread over `LINES` row masks, and in each row a constant 1 is placed at the position of the row's own driven line. Each finished row is then inverted, so a 0 in the mask marks a line that is driven and a 1 marks a line left floating.

A one-cycle `start_i` captures the column bytes. A bit-serial engine then builds one mask bit per cycle. A build-time option selects a byte-parallel engine instead, which builds one mask row per cycle. When every row is complete, all masks are written into the enable file in a single cycle and `done_o` pulses. The scanner reads the enable file continuously, so it never sees a partially built frame.

Top module: `cpx_transposer`

## Requirements
- R1: While reset is asserted and after it is released, `row_en_o` is all ones (every line floating) and `done_o` is 0.
- R2: A `start_i` sampled high while the block is idle starts a conversion. `done_o` goes high exactly `LINES*LINES+1` clock edges after that edge in the serial build, or `LINES+1` edges in the byte-parallel build, and is low during all edges before it.
- R3: `done_o` is high for exactly one cycle per conversion.
- R4: After every conversion, bit `LINES-1-j` of row mask `j` is 0, so each row's own line is always driven.
- R5: For row `j` and line `q != d` with `d = LINES-1-j`, take `p = (LINES-1-q) - (q < d ? 1 : 0)`. Bit `q` of row mask `j` is then the complement of bit `LINES-1-j` of column byte `p`. Column byte `p` is `cols_i[p*LINES +: LINES]` and row mask `j` is `row_en_o[j*LINES +: LINES]`.
- R6: A `start_i` pulse that arrives while a conversion is running has no effect on the result or on the cycle in which `done_o` rises.
- R7: Changes on `cols_i` after the accepting edge have no effect on the conversion in progress.
- R8: `row_en_o` changes only on the edge that raises `done_o`. All row masks are replaced together.
- R9: A `start_i` that is high during the cycle in which `done_o` is high is accepted, so conversions can run back to back.
- R10: Between conversions, `row_en_o` holds the last committed frame whatever `cols_i` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, sampled when idle |
| cols_i | input | (LINES-1)*LINES | Column bytes; byte p at bits [p*LINES +: LINES] |
| done_o | output | 1 | One-cycle pulse when a new frame is committed |
| row_en_o | output | LINES*LINES | Enable file; row j at bits [j*LINES +: LINES], 0 = line driven |

## Verification
The bench sets one column bit at a time across every column byte and bit position. A transposer that skips the diagonal in the wrong place, or fails to reset its column pointer at each row, puts that single bit in the wrong row or line, and the mismatch shows in the walking pattern. Frames of all zeros and all ones isolate the diagonal and the inversion. A design that drops the forced 1 or inverts the wrong way leaves the row's own line floating or drives the whole row. The remaining runs cover stray starts and column changes in the middle of a conversion, a start chained onto the done cycle, and an idle hold. A block that restarts, samples its inputs late, writes rows one at a time, or misses a back-to-back request would shift `done_o`, corrupt the frame, or move `row_en_o` outside the commit edge.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_BUILD  = 2'd1,
      ST_COMMIT = 2'd2
   } cpx_state_e;

   // Edges from the accepting start edge to the edge that raises done.
   function automatic int cpx_latency(input int lines, input bit serial);
      return serial ? (lines * lines + 1) : (lines + 1);
   endfunction

endpackage

// File: rtl/cpx_ctrl.sv
module cpx_ctrl
   import cpx_pkg::*;
#(
   parameter int LINES  = 8,
   parameter bit SERIAL = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start_i,
   output logic                          load_o,
   output logic                          step_o,
   output logic                          diag_o,
   output logic                          byte_end_o,
   output logic                          commit_o,
   output logic [$clog2(LINES+1)-1:0]    off_o
);

   localparam int            CW = $clog2(LINES + 1);
   localparam logic [CW-1:0] LV = CW'(LINES);
   localparam logic [CW-1:0] ONE = CW'(1);

   cpx_state_e     state_q;
   logic [CW-1:0]  off_q;
   logic [CW-1:0]  bc_q;
   logic           bc_last;

   assign load_o     = (state_q == ST_IDLE) && start_i;
   assign step_o     = (state_q == ST_BUILD);
   assign commit_o   = (state_q == ST_COMMIT);
   assign byte_end_o = step_o && bc_last;
   assign off_o      = off_q;

   // Sequence: idle -> build rows -> commit -> idle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         off_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_BUILD;
                  off_q   <= LV;
               end
            end
            ST_BUILD: begin
               if (bc_last) begin
                  if (off_q == ONE) begin
                     state_q <= ST_COMMIT;
                  end else begin
                     off_q <= off_q - ONE;
                  end
               end
            end
            ST_COMMIT: begin
               state_q <= ST_IDLE;
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   generate
      if (SERIAL) begin : g_bit_counter
         // Bit position within the current row, counting down.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bc_q <= '0;
            end else if (load_o) begin
               bc_q <= LV;
            end else if (step_o) begin
               bc_q <= (bc_q == ONE) ? LV : (bc_q - ONE);
            end
         end
         assign bc_last = (bc_q == ONE);
         assign diag_o  = step_o && (bc_q == off_q);
      end else begin : g_row_counter
         // Whole row per step; the bit counter is not needed.
         assign bc_q    = LV;
         assign bc_last = 1'b1;
         assign diag_o  = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/cpx_bit_engine.sv
module cpx_bit_engine #(
   parameter int LINES = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load_i,
   input  logic [(LINES-1)*LINES-1:0]    cols_i,
   input  logic                          step_i,
   input  logic                          diag_i,
   input  logic                          byte_end_i,
   input  logic [$clog2(LINES+1)-1:0]    off_i,
   output logic [LINES*LINES-1:0]        frame_o
);

   localparam int            IB = LINES - 1;
   localparam int            PW = $clog2(IB + 1);
   localparam int            JW = $clog2(LINES);
   localparam int            CW = $clog2(LINES + 1);
   localparam logic [CW-1:0] LV = CW'(LINES);

   logic [LINES-1:0] work_q  [IB];
   logic [LINES-1:0] frame_q [LINES];
   logic [LINES-1:0] acc_q;
   logic [LINES-1:0] acc_nxt;
   logic [PW-1:0]    ptr_q;
   logic [PW-1:0]    ptr_sel;
   logic             in_bit;
   logic             shift_bit;
   logic [CW-1:0]    row_full;
   logic [JW-1:0]    row_idx;

   // The pointer can run one past the last column on a row that ends on
   // its diagonal; clamp the read so it never leaves the array.
   assign ptr_sel   = (ptr_q < PW'(IB)) ? ptr_q : '0;
   assign in_bit    = work_q[ptr_sel][LINES-1];
   assign shift_bit = diag_i ? 1'b1 : in_bit;
   assign acc_nxt   = {acc_q[LINES-2:0], shift_bit};
   assign row_full  = LV - off_i;
   assign row_idx   = row_full[JW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < IB; i++) begin
            work_q[i] <= '0;
         end
         for (int i = 0; i < LINES; i++) begin
            frame_q[i] <= '0;
         end
         acc_q <= '0;
         ptr_q <= '0;
      end else if (load_i) begin
         for (int i = 0; i < IB; i++) begin
            work_q[i] <= cols_i[i*LINES +: LINES];
         end
         acc_q <= '0;
         ptr_q <= '0;
      end else if (step_i) begin
         acc_q <= acc_nxt;
         if (!diag_i) begin
            // Rotate the consumed MSB back into the LSB of that column.
            work_q[ptr_sel] <= {work_q[ptr_sel][LINES-2:0],
                                work_q[ptr_sel][LINES-1]};
         end
         if (byte_end_i) begin
            frame_q[row_idx] <= acc_nxt;
            ptr_q            <= '0;
         end else if (!diag_i) begin
            ptr_q <= ptr_q + PW'(1);
         end
      end
   end

   generate
      for (genvar g = 0; g < LINES; g++) begin : g_frame_out
         assign frame_o[g*LINES +: LINES] = frame_q[g];
      end
   endgenerate

endmodule

// File: rtl/cpx_byte_engine.sv
module cpx_byte_engine #(
   parameter int LINES = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load_i,
   input  logic [(LINES-1)*LINES-1:0]    cols_i,
   input  logic                          step_i,
   input  logic [$clog2(LINES+1)-1:0]    off_i,
   output logic [LINES*LINES-1:0]        frame_o
);

   localparam int            IB = LINES - 1;
   localparam int            JW = $clog2(LINES);
   localparam int            CW = $clog2(LINES + 1);
   localparam logic [CW-1:0] LV = CW'(LINES);

   logic [LINES-1:0] work_q  [IB];
   logic [LINES-1:0] frame_q [LINES];
   logic [LINES-1:0] row_nxt;
   logic [CW-1:0]    row_full;
   logic [JW-1:0]    row_idx;

   assign row_full = LV - off_i;
   assign row_idx  = row_full[JW-1:0];

   // One whole row per step: every column contributes its current MSB,
   // the diagonal position takes a constant 1.
   always_comb begin
      int d;
      int p;
      row_nxt = '0;
      d       = LINES - 1 - int'(row_idx);
      for (int q = 0; q < LINES; q++) begin
         if (q == d) begin
            row_nxt[q] = 1'b1;
         end else begin
            p          = (LINES - 1 - q) - ((q < d) ? 1 : 0);
            row_nxt[q] = work_q[p][LINES-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < IB; i++) begin
            work_q[i] <= '0;
         end
         for (int i = 0; i < LINES; i++) begin
            frame_q[i] <= '0;
         end
      end else if (load_i) begin
         for (int i = 0; i < IB; i++) begin
            work_q[i] <= cols_i[i*LINES +: LINES];
         end
      end else if (step_i) begin
         for (int i = 0; i < IB; i++) begin
            work_q[i] <= {work_q[i][LINES-2:0], work_q[i][LINES-1]};
         end
         frame_q[row_idx] <= row_nxt;
      end
   end

   generate
      for (genvar g = 0; g < LINES; g++) begin : g_frame_out
         assign frame_o[g*LINES +: LINES] = frame_q[g];
      end
   endgenerate

endmodule

// File: rtl/cpx_enable_file.sv
module cpx_enable_file #(
   parameter int LINES = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       commit_i,
   input  logic [LINES*LINES-1:0]     frame_i,
   output logic                       done_o,
   output logic [LINES*LINES-1:0]     row_en_o
);

   // Reset leaves every line floating; a commit swaps in the whole
   // inverted frame at once.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_en_o <= '1;
         done_o   <= 1'b0;
      end else begin
         done_o <= commit_i;
         if (commit_i) begin
            row_en_o <= ~frame_i;
         end
      end
   end

endmodule

// File: rtl/cpx_transposer.sv
module cpx_transposer
   import cpx_pkg::*;
#(
   parameter int LINES  = 8,
   parameter bit SERIAL = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start_i,
   input  logic [(LINES-1)*LINES-1:0]    cols_i,
   output logic                          done_o,
   output logic [LINES*LINES-1:0]        row_en_o
);

   localparam int CW = $clog2(LINES + 1);

   generate
      if (LINES < 3 || LINES > 16) begin : g_bad_lines
         initial $error("cpx_transposer: LINES must be within 3..16");
      end
   endgenerate

   logic                   load;
   logic                   step;
   logic                   diag;
   logic                   byte_end;
   logic                   commit;
   logic [CW-1:0]          off;
   logic [LINES*LINES-1:0] frame;

   cpx_ctrl #(
      .LINES  (LINES),
      .SERIAL (SERIAL)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .load_o     (load),
      .step_o     (step),
      .diag_o     (diag),
      .byte_end_o (byte_end),
      .commit_o   (commit),
      .off_o      (off)
   );

   generate
      if (SERIAL) begin : g_serial
         cpx_bit_engine #(
            .LINES (LINES)
         ) u_engine (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (load),
            .cols_i     (cols_i),
            .step_i     (step),
            .diag_i     (diag),
            .byte_end_i (byte_end),
            .off_i      (off),
            .frame_o    (frame)
         );
      end else begin : g_parallel
         logic unused_ctrl;
         assign unused_ctrl = diag ^ byte_end;
         cpx_byte_engine #(
            .LINES (LINES)
         ) u_engine (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (load),
            .cols_i  (cols_i),
            .step_i  (step),
            .off_i   (off),
            .frame_o (frame)
         );
      end
   endgenerate

   cpx_enable_file #(
      .LINES (LINES)
   ) u_file (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit_i (commit),
      .frame_i  (frame),
      .done_o   (done_o),
      .row_en_o (row_en_o)
   );

endmodule

// File: rtl/cpx_transposer_chk.sv
module cpx_transposer_chk
   import cpx_pkg::*;
#(
   parameter int LINES  = 8,
   parameter bit SERIAL = 1'b1
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       start_i,
   input logic                       done_o,
   input logic [LINES*LINES-1:0]     row_en_o
);

   localparam int LAT = cpx_latency(LINES, SERIAL);
   localparam int KW  = $clog2(LAT + 1);

   logic            busy_q;
   logic [KW-1:0]   cnt_q;
   logic            due;
   logic [LINES-1:0] diag_bits;

   assign due = busy_q && (cnt_q == KW'(LAT));

   // Window counter: edges since the accepted start.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if ((!busy_q || due) && start_i) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (due) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         cnt_q <= cnt_q + KW'(1);
      end
   end

   always_comb begin
      for (int j = 0; j < LINES; j++) begin
         diag_bits[j] = row_en_o[j*LINES + (LINES - 1 - j)];
      end
   end

   // R2: done only at the end of the latency window
   a_r2_done_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> due);

   // R2, R6: done arrives when the window closes
   a_r2_done_when_due: assert property (@(posedge clk) disable iff (!rst_n)
      due |-> done_o);

   // R3
   a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8, R10
   a_r8_file_atomic: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(row_en_o));

   // R4
   a_r4_diag_driven: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (diag_bits == '0));

endmodule

bind cpx_transposer cpx_transposer_chk #(
   .LINES  (LINES),
   .SERIAL (SERIAL)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .done_o   (done_o),
   .row_en_o (row_en_o)
);

// File: tb/sim_cpx_transposer.sv
`timescale 1ns/1ps
module sim_cpx_transposer;

   localparam int N   = 8;
   localparam int IB  = N - 1;
   localparam int LAT = N * N + 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [IB*N-1:0]   cols = '0;
   logic              done;
   logic [N*N-1:0]    row_en;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   cpx_transposer #(.LINES(N), .SERIAL(1'b1)) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .cols_i   (cols),
      .done_o   (done),
      .row_en_o (row_en)
   );

   // Expected enable file from the mapping rule (R4, R5).
   function automatic logic [N*N-1:0] model(input logic [IB*N-1:0] c);
      logic [N*N-1:0] r;
      for (int j = 0; j < N; j++) begin
         int d;
         d = N - 1 - j;
         for (int q = 0; q < N; q++) begin
            logic b;
            if (q == d) begin
               b = 1'b1;
            end else begin
               int p;
               p = (N - 1 - q) - ((q < d) ? 1 : 0);
               b = c[p*N + (N - 1 - j)];
            end
            r[j*N + q] = ~b;
         end
      end
      return r;
   endfunction

   task automatic chk(input bit ok, input string req,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // One conversion. prestarted: the accepting edge has already passed.
   task automatic run_conv(input logic [IB*N-1:0] c, input bit disturb,
                           input bit prestarted, input bit chain,
                           input logic [IB*N-1:0] nxt, input string req);
      logic [N*N-1:0] exp;
      logic [N*N-1:0] prev;
      int bad_done;
      int bad_hold;
      exp = model(c);
      if (!prestarted) begin
         @(negedge clk);
         cols  = c;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      prev     = row_en;
      bad_done = 0;
      bad_hold = 0;
      for (int k = 1; k <= LAT; k++) begin
         @(negedge clk);
         if (k < LAT) begin
            if (done) bad_done++;
            if (row_en != prev) bad_hold++;
         end else begin
            chk(done == 1'b1, "R2 done at latency", 64'(done), 64'd1);
            chk(row_en == exp, req, row_en, exp);
            for (int j = 0; j < N; j++) begin
               if (row_en[j*N + (N-1-j)] != 1'b0) bad_hold += 1000;
            end
         end
         if (disturb && k == 5) begin
            start = 1'b1;
            cols  = ~c;
         end
         if (disturb && k == 6) start = 1'b0;
         if (chain && k == LAT) begin
            cols  = nxt;
            start = 1'b1;
         end
      end
      chk(bad_done == 0, "R2 no early done", 64'(bad_done), 64'd0);
      chk(bad_hold < 1000, "R4 diagonal driven", 64'(bad_hold / 1000), 64'd0);
      chk((bad_hold % 1000) == 0, "R8 file stable before commit",
          64'(bad_hold % 1000), 64'd0);
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b0, "R3 done one cycle", 64'(done), 64'd0);
   endtask

   initial begin
      logic [63:0]     s;
      logic [IB*N-1:0] a;
      logic [IB*N-1:0] b;
      logic [N*N-1:0]  held;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(row_en == '1, "R1 reset file", row_en, '1);
      chk(done == 1'b0, "R1 reset done", 64'(done), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(row_en == '1, "R1 file after release", row_en, '1);
      chk(done == 1'b0, "R1 done after release", 64'(done), 64'd0);

      // R5: corner frames
      run_conv('0, 1'b0, 1'b0, 1'b0, '0, "R5 all zero");
      run_conv('1, 1'b0, 1'b0, 1'b0, '0, "R5 all ones");

      // R5: walking single bit over every column bit
      for (int p = 0; p < IB; p++) begin
         for (int bt = 0; bt < N; bt++) begin
            a = '0;
            a[p*N + bt] = 1'b1;
            run_conv(a, 1'b0, 1'b0, 1'b0, '0, "R5 walking bit");
         end
      end

      // R5: arithmetic mixed patterns
      s = 64'h9E3779B97F4A7C15;
      for (int i = 0; i < 10; i++) begin
         s = s ^ (s << 13);
         s = s ^ (s >> 7);
         s = s ^ (s << 17);
         run_conv(s[IB*N-1:0], 1'b0, 1'b0, 1'b0, '0, "R5 mixed");
      end

      // R6, R7: stray start and column change mid-conversion
      run_conv(56'h0F_1E_3C_78_F0_E1_C3, 1'b1, 1'b0, 1'b0, '0,
               "R6 R7 stray start ignored");
      run_conv(56'hA5_5A_A5_5A_A5_5A_A5, 1'b1, 1'b0, 1'b0, '0,
               "R6 R7 cols change ignored");

      // R9: back-to-back on the done cycle
      a = 56'h01_23_45_67_89_AB_CD;
      b = 56'hFE_DC_BA_98_76_54_32;
      run_conv(a, 1'b0, 1'b0, 1'b1, b, "R9 first of pair");
      run_conv(b, 1'b0, 1'b1, 1'b0, '0, "R9 chained conversion");

      // R10: hold while idle with moving columns
      held = row_en;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         cols = {cols[IB*N-2:0], ~cols[IB*N-1]};
      end
      @(negedge clk);
      chk(row_en == held, "R10 idle hold", row_en, held);
      chk(done == 1'b0, "R10 no done while idle", 64'(done), 64'd0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule